// File: doc/BRIEF.md
# Self-Starting Five-Step Sequence Counter

This block is a 3-bit counter that walks a fixed loop of five codes which do not follow binary order. Each enabled clock moves it one step along the loop; with the enable low it keeps its code. The three codes outside the loop each have a defined successor. Whatever value the register holds, the counter is therefore back on the loop after at most two enabled clocks.

The output is the present code, with bit 2 as C, bit 1 as B and bit 0 as A. A flag next to it is high when the code lies on the loop. A synchronous active-low reset loads a start code set by a parameter. The default start code is 000. Any of the eight codes may be chosen, so a chip can start the counter off the loop on purpose, and a test can do the same to exercise recovery.

Top module: `fivecycle_counter`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the code loads `INIT_CODE` (default 000), whatever `en_i` is.
- R2: With `en_i` high, the loop codes follow each other as 000 → 010 → 011 → 101 → 110 → 000, one step per clock.
- R3: With `rst_n` high and `en_i` low at a rising edge, the code stays the same, including when it is off the loop.
- R4: With `en_i` high, code 001 moves to 110.
- R5: With `en_i` high, code 100 moves to 010.
- R6: With `en_i` high, code 111 moves to 100, and from there to 010.
- R7: Starting from any of the eight codes, at most two enabled clocks bring the code onto the loop.
- R8: `valid_o` is 1 exactly when `code_o` is 000, 010, 011, 101 or 110, and 0 for 001, 100 and 111.
- R9: `code_o[2]` is C, `code_o[1]` is B and `code_o[0]` is A. The next C equals the present A.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low, loads INIT_CODE |
| en_i | input | 1 | Advance enable; when low the code holds |
| code_o | output | 3 | Present code {C,B,A} |
| valid_o | output | 1 | High when code_o lies on the five-code loop |

## Verification
Two pairs of functions can act in the same cycle. Reset and enable can both be asserted, and an enable-low hold can land while the code is one of the unused values. The bench drives reset together with enable high and expects the start code, not a step. Copies of the counter whose start code is 001, 100 or 111 are held with enable low right after reset. They must keep their off-loop code with the flag low until enable rises, and then reach the loop inside two clocks. A behavioural model built from a lookup of successors judges every clock.

// File: rtl/seqc_pkg.sv
package seqc_pkg;
  localparam int CODE_W = 3;
  typedef logic [CODE_W-1:0] code_t;

  localparam code_t LOOP_0 = 3'b000;
  localparam code_t LOOP_1 = 3'b010;
  localparam code_t LOOP_2 = 3'b011;
  localparam code_t LOOP_3 = 3'b101;
  localparam code_t LOOP_4 = 3'b110;

  localparam int BIT_C = 2;
  localparam int BIT_B = 1;
  localparam int BIT_A = 0;
endpackage

// File: rtl/seqc_next.sv
module seqc_next
  import seqc_pkg::*;
(
  input  code_t cur_i,
  output code_t nxt_o
);
  logic c, b, a;

  always_comb begin
    c = cur_i[BIT_C];
    b = cur_i[BIT_B];
    a = cur_i[BIT_A];
    nxt_o        = '0;
    nxt_o[BIT_C] = a;
    nxt_o[BIT_B] = ~b | (~a & ~c);
    nxt_o[BIT_A] = b & ~c;
  end
endmodule

// File: rtl/seqc_valid.sv
module seqc_valid
  import seqc_pkg::*;
(
  input  code_t cur_i,
  output logic  on_loop_o
);
  always_comb begin
    unique case (cur_i)
      LOOP_0, LOOP_1, LOOP_2, LOOP_3, LOOP_4: on_loop_o = 1'b1;
      default:                                on_loop_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/seqc_state_reg.sv
module seqc_state_reg
  import seqc_pkg::*;
#(
  parameter code_t INIT_CODE = 3'b000
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  en_i,
  input  code_t d_i,
  output code_t q_o
);
  code_t q_r;
  code_t q_nxt;

  always_comb begin
    q_nxt = q_r;
    if (!rst_n)    q_nxt = INIT_CODE;
    else if (en_i) q_nxt = d_i;
  end

  always_ff @(posedge clk) begin
    q_r <= q_nxt;
  end

  assign q_o = q_r;

  // R1: the first edge after reset sees the start code
  assert_reset_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (q_r == INIT_CODE));

  // R3: an idle cycle leaves the code alone
  assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> $stable(q_r));
endmodule

// File: rtl/fivecycle_counter.sv
module fivecycle_counter
  import seqc_pkg::*;
#(
  parameter logic [2:0] INIT_CODE = 3'b000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_i,
  output logic [2:0] code_o,
  output logic       valid_o
);
  code_t cur;
  code_t nxt;
  logic  on_loop;

  seqc_next u_next (
    .cur_i (cur),
    .nxt_o (nxt)
  );

  seqc_state_reg #(.INIT_CODE(INIT_CODE)) u_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .en_i  (en_i),
    .d_i   (nxt),
    .q_o   (cur)
  );

  seqc_valid u_valid (
    .cur_i     (cur),
    .on_loop_o (on_loop)
  );

  assign code_o  = cur;
  assign valid_o = on_loop;

  // R2: once on the loop, enabled steps stay on it
  assert_loop_closed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && valid_o) |=> valid_o);

  // R4: recovery from 001
  assert_recover_001_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && code_o == 3'b001) |=> (code_o == 3'b110));

  // R5: recovery from 100
  assert_recover_100_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && code_o == 3'b100) |=> (code_o == 3'b010));

  // R6: recovery from 111
  assert_recover_111_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && code_o == 3'b111) |=> (code_o == 3'b100));

  // R7: an off-loop code other than 111 rejoins in one enabled step
  assert_rejoin_one_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !valid_o && code_o != 3'b111) |=> valid_o);
endmodule

// File: tb/fivecycle_counter_tb_top.sv
module fivecycle_counter_tb_top;
  logic clk;
  logic rst_n;
  logic en;
  logic [2:0] code0, code1, code4, code7;
  logic       val0, val1, val4, val7;
  int n_chk;
  int n_fail;
  int mdl [4];
  int init_c [4];

  initial clk = 1'b0;
  always #2 clk = ~clk;

  fivecycle_counter dut_i (.clk(clk), .rst_n(rst_n), .en_i(en), .code_o(code0), .valid_o(val0));
  fivecycle_counter #(.INIT_CODE(3'b001)) rec1_i (.clk(clk), .rst_n(rst_n), .en_i(en), .code_o(code1), .valid_o(val1));
  fivecycle_counter #(.INIT_CODE(3'b100)) rec4_i (.clk(clk), .rst_n(rst_n), .en_i(en), .code_o(code4), .valid_o(val4));
  fivecycle_counter #(.INIT_CODE(3'b111)) rec7_i (.clk(clk), .rst_n(rst_n), .en_i(en), .code_o(code7), .valid_o(val7));

  function automatic int succ(int s);
    case (s)
      0: return 2;
      2: return 3;
      3: return 5;
      5: return 6;
      6: return 0;
      1: return 6;
      4: return 2;
      default: return 4;
    endcase
  endfunction

  function automatic bit on_loop(int s);
    return (s == 0) || (s == 2) || (s == 3) || (s == 5) || (s == 6);
  endfunction

  function automatic int get_code(int k);
    case (k)
      0: return int'(code0);
      1: return int'(code1);
      2: return int'(code4);
      default: return int'(code7);
    endcase
  endfunction

  function automatic bit get_val(int k);
    case (k)
      0: return val0;
      1: return val1;
      2: return val4;
      default: return val7;
    endcase
  endfunction

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // called at a falling edge; applies inputs, advances model, compares
  task automatic step(bit r, bit e);
    string tag [4];
    rst_n = r;
    en    = e;
    @(posedge clk);
    for (int k = 0; k < 4; k++) begin
      if (!r) begin
        tag[k] = "R1";
        mdl[k] = init_c[k];
      end else if (!e) begin
        tag[k] = "R3";
      end else begin
        case (mdl[k])
          1: tag[k] = "R4";
          4: tag[k] = "R5";
          7: tag[k] = "R6";
          default: tag[k] = "R2";
        endcase
        mdl[k] = succ(mdl[k]);
      end
    end
    @(negedge clk);
    for (int k = 0; k < 4; k++) begin
      check(tag[k], get_code(k), mdl[k]);
      check("R8", int'(get_val(k)), int'(on_loop(mdl[k])));
    end
  endtask

  initial begin
    #100000;
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int lfsr;
    int steps;
    n_chk = 0;
    n_fail = 0;
    init_c[0] = 0; init_c[1] = 1; init_c[2] = 4; init_c[3] = 7;
    for (int k = 0; k < 4; k++) mdl[k] = 0;
    rst_n = 1'b0;
    en    = 1'b1;
    @(negedge clk);
    // R1: reset with enable high loads start codes
    step(0, 1);
    step(0, 1);
    // R3 with off-loop codes: hold 001/100/111 while enable low
    step(1, 0);
    step(1, 0);
    check("R3", int'(code7), 7);
    // R6/R7: 111 -> 100 -> 010 within two enabled clocks
    steps = 0;
    while (!val7 && steps < 4) begin
      step(1, 1);
      steps++;
    end
    check("R7", int'(steps <= 2), 1);
    // R2: walk the loop several times
    for (int i = 0; i < 12; i++) step(1, 1);
    // R9: from 011 the next C bit is 1
    step(0, 0);
    step(1, 1);
    step(1, 1);
    check("R9", int'(code0), 3);
    step(1, 1);
    check("R9", int'(code0[2]), 1);
    // mixed enable pattern with an occasional reset
    lfsr = 32'h5a;
    for (int i = 0; i < 60; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      step(!(lfsr[7:0] == 8'h11 || i == 37), lfsr[2] | lfsr[5]);
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule